// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits beside the fetch stage of a small 8-bit microcontroller core and carries out the hardware part of taking an interrupt. Each cycle it is idle, it looks at a reset request, a vector of pending interrupt source bits and the global interrupt enable flag. When the flag is set and something is pending, it picks one request, stores the current word program counter on the stack one byte per cycle through a byte-wide data memory write port, and then hands the core a new program counter, a new stack pointer, a strobe that clears the global enable flag and an acknowledge naming the serviced source.

A reset request outranks every hardware source and uses vector slot zero. A hardware source at bit n uses slot n+1, and when several are pending the one with the smallest bit index is served. The vector address is the slot number times the vector size, which is two words when the core has two-word jump and call instructions and one word otherwise. The program counter width sets how many bytes are pushed: three above 16 bits, two above 8 bits, one otherwise. The bytes go out least significant first, each stored at the current stack pointer, which then drops by one.

While the sequence runs, `busy` stalls the core's fetch. The core applies `pc_next`, `sp_next` and the enable clear in the single cycle in which `pc_load` is high, and writes `pend_left` back as its new pending set.

Top module: `irq_entry_seq`

## Requirements
- R1: With `gie` low, no sequence starts, whatever `rst_req` and `irq_pend` hold: `busy`, `mem_we` and `pc_load` stay 0.
- R2: With `gie` high and several bits of `irq_pend` set (and `rst_req` low), the bit with the lowest index is served.
- R3: With `gie` high, `rst_req` high takes precedence over any pending bits, uses vector slot 0 (so `pc_next` is 0) and is acknowledged with `ack_reset`=1 and `ack_mask`=0.
- R4: A hardware source at bit n gives `pc_next` = (n+1) x 2 when `LONG_VEC`=1 and (n+1) when `LONG_VEC`=0, truncated to `PC_W` bits.
- R5: The push writes one byte per cycle starting in the cycle after acceptance: byte k of the return PC (bits 8k+7..8k, least significant first) is written with `mem_we`=1 at address `sp_cur`-k, modulo 2^`SP_W`.
- R6: The number of pushed bytes is 3 when `PC_W`>16, 2 when 8<`PC_W`<=16, and 1 otherwise; in the load cycle `sp_next` equals `sp_cur` minus that count, modulo 2^`SP_W`.
- R7: The cycle right after the last push is the load cycle: `pc_load`, `sp_load`, `gie_clr` and `ack_valid` are all 1 for exactly that cycle, with `mem_we`=0.
- R8: For a hardware source the acknowledge gives a one-hot `ack_mask` of the served bit, `pend_left` = pending AND (pending - 1) and `pend_more` = 1 when `pend_left` is non-zero; for a reset request `pend_left` is the pending set unchanged.
- R9: After reset `busy`, `mem_we` and `pc_load` are 0; `busy` is 1 from the first push cycle through the load cycle and 0 in the cycle after.
- R10: Changes on `rst_req`, `irq_pend`, `pc_cur` and `sp_cur` after acceptance do not alter the pushed bytes, addresses, vector or acknowledge of the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rst_req | input | 1 | Reset request, served through vector slot 0 |
| gie | input | 1 | Global interrupt enable flag of the core |
| irq_pend | input | NUM_SRC | Pending hardware interrupt sources |
| pc_cur | input | PC_W | Word program counter to save |
| sp_cur | input | SP_W | Current stack pointer |
| busy | output | 1 | Entry sequence in progress; stalls fetch |
| mem_we | output | 1 | Data memory byte write strobe |
| mem_addr | output | SP_W | Data memory write address |
| mem_wdata | output | 8 | Data memory write byte |
| pc_load | output | 1 | Load `pc_next` into the program counter |
| pc_next | output | PC_W | Vector address |
| sp_load | output | 1 | Load `sp_next` into the stack pointer |
| sp_next | output | SP_W | Stack pointer after the push |
| gie_clr | output | 1 | Clear the global interrupt enable flag |
| ack_valid | output | 1 | Acknowledge strobe |
| ack_reset | output | 1 | The served request was the reset request |
| ack_mask | output | NUM_SRC | One-hot mask of the served hardware source |
| pend_left | output | NUM_SRC | Pending set with the served bit removed |
| pend_more | output | 1 | Hardware sources are still pending after this one |

## Verification
The assertions assume the core honours the handshake: it lowers `gie` in response to `gie_clr` before the block is idle again, so no second entry follows the load cycle straight away, and it samples the results only while `pc_load` is high. The stimulus keeps to this by raising `gie` only for the acceptance cycle and dropping it in the first push cycle, while pending bits, the reset request, the program counter and the stack pointer are rescrambled during the sequence to show they are no longer looked at. Three copies with 22-, 16- and 8-bit program counters and both vector sizes receive the same stimulus, which mixes random pending patterns with directed cases such as stack pointer wrap, the top source alone, all sources at once and reset together with sources.

// File: rtl/irq_seq_pkg.sv
// Package: shared constants, state encoding and sizing helpers for the
// interrupt entry sequencer. Assumes program counters of at most 24 bits.
package irq_seq_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_LOAD = 2'd2
    } seq_state_t;

    // Number of return-address bytes stored for a given PC width.
    function automatic int pc_byte_count(input int pc_w);
        if (pc_w > 16)
            return 3;
        else if (pc_w > 8)
            return 2;
        else
            return 1;
    endfunction

endpackage

// File: rtl/irq_arbiter.sv
// Module: fixed-priority arbiter over the pending source vector.
// The lowest set bit wins. Purely combinational; assumes NUM_SRC >= 2.
module irq_arbiter #(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] pend,
    output logic               found,
    output logic [IDX_W-1:0]   win_idx,
    output logic [NUM_SRC-1:0] win_mask,
    output logic [NUM_SRC-1:0] rest
);

    // lower_set[i] is high when any bit below i is pending
    logic [NUM_SRC-1:0] lower_set;

    assign lower_set[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 1; gi < NUM_SRC; gi++) begin : g_chain
            assign lower_set[gi] = lower_set[gi-1] | pend[gi-1];
        end
        for (gi = 0; gi < NUM_SRC; gi++) begin : g_grant
            assign win_mask[gi] = pend[gi] & ~lower_set[gi];
        end
    endgenerate

    // Encode the one-hot winner into a bit index.
    always_comb begin
        win_idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (win_mask[i])
                win_idx = IDX_W'(i);
        end
    end

    assign found = |pend;
    assign rest  = pend & ~win_mask;

endmodule

// File: rtl/irq_vector_gen.sv
// Module: turns the selected request into a vector address.
// Slot 0 belongs to reset, hardware source n uses slot n+1; the slot is
// scaled by the vector size (2 words with long jumps, 1 word otherwise).
module irq_vector_gen #(
    parameter int NUM_SRC  = 8,
    parameter int PC_W     = 22,
    parameter bit LONG_VEC = 1'b1,
    localparam int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic             is_reset,
    input  logic [IDX_W-1:0] src_idx,
    output logic [PC_W-1:0]  vec_pc
);

    localparam int SLOT_W = $clog2(NUM_SRC + 1);
    localparam int TMP_W  = SLOT_W + PC_W + 1;

    logic [SLOT_W-1:0] slot;
    logic [TMP_W-1:0]  scaled;

    // Reserve slot zero for the reset request.
    always_comb begin
        if (is_reset)
            slot = '0;
        else
            slot = SLOT_W'(src_idx) + SLOT_W'(1);
    end

    generate
        if (LONG_VEC) begin : g_two_word
            assign scaled = TMP_W'(slot) << 1;
        end else begin : g_one_word
            assign scaled = TMP_W'(slot);
        end
    endgenerate

    assign vec_pc = scaled[PC_W-1:0];

endmodule

// File: rtl/irq_stack_pusher.sv
// Module: return-address shifter and stack pointer tracker.
// On load it captures the PC and SP; each step retires the low byte and
// decrements the SP. Byte and address always show the next store.
module irq_stack_pusher #(
    parameter int PC_W = 22,
    parameter int SP_W = 16,
    localparam int NB  = irq_seq_pkg::pc_byte_count(PC_W),
    localparam int SH_W = NB * irq_seq_pkg::BYTE_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic                          step,
    input  logic [PC_W-1:0]               pc_in,
    input  logic [SP_W-1:0]               sp_in,
    output logic [irq_seq_pkg::BYTE_W-1:0] byte_out,
    output logic [SP_W-1:0]               addr_out
);

    logic [SH_W-1:0] shreg;
    logic [SP_W-1:0] sp_q;

    // Capture or shift the return address, low byte first.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= '0;
        else if (load)
            shreg <= SH_W'(pc_in);
        else if (step)
            shreg <= shreg >> irq_seq_pkg::BYTE_W;
    end

    // Capture the stack pointer or post-decrement it after each store.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp_q <= '0;
        else if (load)
            sp_q <= sp_in;
        else if (step)
            sp_q <= sp_q - SP_W'(1);
    end

    assign byte_out = shreg[irq_seq_pkg::BYTE_W-1:0];
    assign addr_out = sp_q;

endmodule

// File: rtl/irq_entry_seq.sv
// Module: interrupt entry sequencer top.
// Accepts a request in idle when the global enable is set, pushes the
// return PC byte by byte, then presents vector, new SP, enable clear and
// acknowledge for one cycle. Assumes the core drops gie on gie_clr and
// stalls fetch while busy is high.
module irq_entry_seq #(
    parameter int NUM_SRC  = 8,
    parameter int PC_W     = 22,
    parameter int SP_W     = 16,
    parameter bit LONG_VEC = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rst_req,
    input  logic               gie,
    input  logic [NUM_SRC-1:0] irq_pend,
    input  logic [PC_W-1:0]    pc_cur,
    input  logic [SP_W-1:0]    sp_cur,
    output logic               busy,
    output logic               mem_we,
    output logic [SP_W-1:0]    mem_addr,
    output logic [7:0]         mem_wdata,
    output logic               pc_load,
    output logic [PC_W-1:0]    pc_next,
    output logic               sp_load,
    output logic [SP_W-1:0]    sp_next,
    output logic               gie_clr,
    output logic               ack_valid,
    output logic               ack_reset,
    output logic [NUM_SRC-1:0] ack_mask,
    output logic [NUM_SRC-1:0] pend_left,
    output logic               pend_more
);

    import irq_seq_pkg::*;

    localparam int IDX_W   = $clog2(NUM_SRC);
    localparam int NB      = pc_byte_count(PC_W);
    localparam int CNT_W   = 2;
    localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(NB - 1);

    seq_state_t          state_q;
    logic [CNT_W-1:0]    cnt_q;
    logic                accept;
    logic                arb_found;
    logic [IDX_W-1:0]    arb_idx;
    logic [NUM_SRC-1:0]  arb_mask;
    logic [NUM_SRC-1:0]  arb_rest;
    logic [PC_W-1:0]     vec_pc;
    logic                rst_sel_q;
    logic [NUM_SRC-1:0]  mask_q;
    logic [NUM_SRC-1:0]  left_q;
    logic [PC_W-1:0]     vec_q;
    logic                push_step;

    irq_arbiter #(
        .NUM_SRC (NUM_SRC)
    ) u_arb (
        .pend     (irq_pend),
        .found    (arb_found),
        .win_idx  (arb_idx),
        .win_mask (arb_mask),
        .rest     (arb_rest)
    );

    irq_vector_gen #(
        .NUM_SRC  (NUM_SRC),
        .PC_W     (PC_W),
        .LONG_VEC (LONG_VEC)
    ) u_vec (
        .is_reset (rst_req),
        .src_idx  (arb_idx),
        .vec_pc   (vec_pc)
    );

    irq_stack_pusher #(
        .PC_W (PC_W),
        .SP_W (SP_W)
    ) u_push (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .step     (push_step),
        .pc_in    (pc_cur),
        .sp_in    (sp_cur),
        .byte_out (mem_wdata),
        .addr_out (mem_addr)
    );

    // Start a sequence only from idle with the enable set and a request present.
    assign accept    = (state_q == ST_IDLE) && gie && (rst_req || arb_found);
    assign push_step = (state_q == ST_PUSH);

    // Sequence state: idle, one push cycle per byte, then the load cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (accept)
                        state_q <= ST_PUSH;
                end
                ST_PUSH: begin
                    cnt_q <= cnt_q + CNT_W'(1);
                    if (cnt_q == LAST_BYTE)
                        state_q <= ST_LOAD;
                end
                ST_LOAD: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Snapshot the choice, vector and remaining pending set at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_sel_q <= 1'b0;
            mask_q    <= '0;
            left_q    <= '0;
            vec_q     <= '0;
        end else if (accept) begin
            rst_sel_q <= rst_req;
            mask_q    <= rst_req ? '0 : arb_mask;
            left_q    <= rst_req ? irq_pend : arb_rest;
            vec_q     <= vec_pc;
        end
    end

    // Drive the core-facing strobes from the registered state.
    always_comb begin
        busy      = (state_q != ST_IDLE);
        mem_we    = (state_q == ST_PUSH);
        pc_load   = (state_q == ST_LOAD);
        sp_load   = (state_q == ST_LOAD);
        gie_clr   = (state_q == ST_LOAD);
        ack_valid = (state_q == ST_LOAD);
    end

    assign pc_next   = vec_q;
    assign sp_next   = mem_addr;
    assign ack_reset = rst_sel_q;
    assign ack_mask  = mask_q;
    assign pend_left = left_q;
    assign pend_more = |left_q;

endmodule

// File: rtl/irq_entry_seq_chk.sv
// Module: property checker for the interrupt entry sequencer, bound to
// every instance of the top. Assumes the core lowers gie on gie_clr.
module irq_entry_seq_chk #(
    parameter int NUM_SRC = 8,
    parameter int SP_W    = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               gie,
    input logic               busy,
    input logic               mem_we,
    input logic [SP_W-1:0]    mem_addr,
    input logic               pc_load,
    input logic               gie_clr,
    input logic               ack_valid,
    input logic               ack_reset,
    input logic [NUM_SRC-1:0] ack_mask,
    input logic [NUM_SRC-1:0] pend_left
);

    // R1: an idle block with the enable low stays idle.
    p_no_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !gie) |=> !busy);

    // R5: consecutive pushes step the address down by one.
    p_push_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - SP_W'(1)));

    // R7: the load cycle carries every completion strobe and no store.
    p_load_strobes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> (gie_clr && ack_valid && busy && !mem_we));

    // R7: the load cycle follows a push cycle.
    p_load_after_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pc_load) |-> $past(mem_we));

    // R8: a reset acknowledge names no source, a hardware one names exactly one.
    p_ack_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> ($countones(ack_mask) == (ack_reset ? 0 : 1)));

    // R8: the served bit is gone from the remaining pending set.
    p_ack_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> ((pend_left & ack_mask) == '0));

    // R9: busy ends right after the load cycle.
    p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !busy);

    // R9: a sequence starts with a store and stores only while busy.
    p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> mem_we);

    p_we_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

endmodule

bind irq_entry_seq irq_entry_seq_chk #(
    .NUM_SRC (NUM_SRC),
    .SP_W    (SP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gie       (gie),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .pc_load   (pc_load),
    .gie_clr   (gie_clr),
    .ack_valid (ack_valid),
    .ack_reset (ack_reset),
    .ack_mask  (ack_mask),
    .pend_left (pend_left)
);

// File: tb/irq_entry_seq_test.sv
`timescale 1ns/1ps
// Bench: three sequencer copies (22-bit PC with two-word vectors, 16-bit PC
// with two-word vectors, 8-bit PC with one-word vectors) share one stimulus.
module irq_entry_seq_test;

    localparam int NSRC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_req = 1'b0;
    logic        gie = 1'b0;
    logic [7:0]  pend = '0;
    logic [21:0] pc_drv = '0;
    logic [15:0] sp_drv = '0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic        busy_a  [3];
    logic        we_a    [3];
    logic [15:0] addr_a  [3];
    logic [7:0]  wd_a    [3];
    logic        ld_a    [3];
    logic [21:0] pco_a   [3];
    logic        spld_a  [3];
    logic [15:0] spo_a   [3];
    logic        gclr_a  [3];
    logic        ackv_a  [3];
    logic        ackr_a  [3];
    logic [7:0]  mask_a  [3];
    logic [7:0]  left_a  [3];
    logic        more_a  [3];

    always #2 clk = ~clk;

    for (genvar g = 0; g < 3; g++) begin : g_dut
        localparam int PW = (g == 0) ? 22 : ((g == 1) ? 16 : 8);
        localparam bit LV = (g != 2);
        logic [PW-1:0] pco_w;
        logic          busy_w, we_w, ld_w, spld_w, gclr_w, ackv_w, ackr_w, more_w;
        logic [15:0]   addr_w, spo_w;
        logic [7:0]    wd_w, mask_w, left_w;

        irq_entry_seq #(
            .NUM_SRC  (NSRC),
            .PC_W     (PW),
            .SP_W     (16),
            .LONG_VEC (LV)
        ) uut (
            .clk       (clk),
            .rst_n     (rst_n),
            .rst_req   (rst_req),
            .gie       (gie),
            .irq_pend  (pend),
            .pc_cur    (pc_drv[PW-1:0]),
            .sp_cur    (sp_drv),
            .busy      (busy_w),
            .mem_we    (we_w),
            .mem_addr  (addr_w),
            .mem_wdata (wd_w),
            .pc_load   (ld_w),
            .pc_next   (pco_w),
            .sp_load   (spld_w),
            .sp_next   (spo_w),
            .gie_clr   (gclr_w),
            .ack_valid (ackv_w),
            .ack_reset (ackr_w),
            .ack_mask  (mask_w),
            .pend_left (left_w),
            .pend_more (more_w)
        );

        assign busy_a[g] = busy_w;
        assign we_a[g]   = we_w;
        assign addr_a[g] = addr_w;
        assign wd_a[g]   = wd_w;
        assign ld_a[g]   = ld_w;
        assign pco_a[g]  = 22'(pco_w);
        assign spld_a[g] = spld_w;
        assign spo_a[g]  = spo_w;
        assign gclr_a[g] = gclr_w;
        assign ackv_a[g] = ackv_w;
        assign ackr_a[g] = ackr_w;
        assign mask_a[g] = mask_w;
        assign left_a[g] = left_w;
        assign more_a[g] = more_w;
    end

    function automatic int pw_of(input int i);
        return (i == 0) ? 22 : ((i == 1) ? 16 : 8);
    endfunction

    function automatic int nbytes_of(input int i);
        return 3 - i;
    endfunction

    function automatic int lowest_bit(input logic [7:0] p);
        for (int b = 0; b < 8; b++)
            if (p[b]) return b;
        return 0;
    endfunction

    // Expected vector address from the requirements (R3, R4).
    function automatic logic [21:0] exp_vec(input int i, input bit r, input logic [7:0] p);
        int slot;
        int vs;
        slot = r ? 0 : lowest_bit(p) + 1;
        vs   = (i == 2) ? 1 : 2;
        return 22'((slot * vs) & ((1 << pw_of(i)) - 1));
    endfunction

    task automatic chk(input string req, input int inst, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s inst%0d act=%0h exp=%0h", req, inst, act, exp);
        end
    endtask

    // One entry attempt; checks every copy for five cycles after acceptance.
    task automatic run_trial(input bit ge, input bit r, input logic [7:0] p,
                             input logic [21:0] pc, input logic [15:0] sp);
        bit take;
        logic [7:0] lowm;
        take = ge && (r || (p != 0));
        lowm = p & (~p + 8'd1);
        @(negedge clk);
        gie = ge; rst_req = r; pend = p; pc_drv = pc; sp_drv = sp;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            for (int i = 0; i < 3; i++) begin
                int nb;
                logic [21:0] pcm;
                nb  = nbytes_of(i);
                pcm = pc & 22'((1 << pw_of(i)) - 1);
                if (!take) begin
                    chk("R1 busy", i, 32'(busy_a[i]), 0);
                    chk("R1 we", i, 32'(we_a[i]), 0);
                    chk("R1 load", i, 32'(ld_a[i]), 0);
                end else if (k <= nb) begin
                    chk("R9 busy push", i, 32'(busy_a[i]), 1);
                    chk("R5 we", i, 32'(we_a[i]), 1);
                    chk("R5 addr", i, 32'(addr_a[i]), 32'(16'(sp - 16'(k - 1))));
                    chk("R5 byte R10", i, 32'(wd_a[i]), 32'((pcm >> (8 * (k - 1))) & 22'hff));
                    chk("R7 no load", i, 32'(ld_a[i]), 0);
                end else if (k == nb + 1) begin
                    chk("R9 busy load", i, 32'(busy_a[i]), 1);
                    chk("R7 we", i, 32'(we_a[i]), 0);
                    chk("R7 strobes", i, {28'd0, ld_a[i], spld_a[i], gclr_a[i], ackv_a[i]}, 32'hf);
                    chk(r ? "R3 vec" : "R2 R4 vec", i, 32'(pco_a[i]), 32'(exp_vec(i, r, p)));
                    chk("R6 sp", i, 32'(spo_a[i]), 32'(16'(sp - 16'(nb))));
                    chk("R3 R8 ackr", i, 32'(ackr_a[i]), 32'(r));
                    chk("R8 mask", i, 32'(mask_a[i]), r ? 32'd0 : 32'(lowm));
                    chk("R8 left", i, 32'(left_a[i]), r ? 32'(p) : 32'(p & (p - 8'd1)));
                    chk("R8 more", i, 32'(more_a[i]), r ? 32'(p != 0) : 32'((p & (p - 8'd1)) != 0));
                end else begin
                    chk("R9 idle", i, 32'(busy_a[i]), 0);
                    chk("R9 load off", i, 32'(ld_a[i]), 0);
                end
            end
            if (k == 1) begin
                // R10: scramble inputs once the sequences are under way.
                gie     = 1'b0;
                rst_req = 1'($urandom);
                pend    = 8'($urandom);
                pc_drv  = 22'($urandom);
                sp_drv  = 16'($urandom);
            end
        end
    endtask

    initial begin
        void'($urandom(32'h1d5e_a7c3));
        repeat (3) @(negedge clk);
        // R9: reset state.
        for (int i = 0; i < 3; i++) begin
            chk("R9 reset busy", i, 32'(busy_a[i]), 0);
            chk("R9 reset we", i, 32'(we_a[i]), 0);
            chk("R9 reset load", i, 32'(ld_a[i]), 0);
        end
        rst_n = 1'b1;
        // Directed corner cases.
        run_trial(1'b0, 1'b1, 8'hff, 22'h2a5c3e, 16'h0800);   // R1 enable low
        run_trial(1'b1, 1'b0, 8'h00, 22'h00ff00, 16'h0400);   // R1 nothing pending
        run_trial(1'b1, 1'b1, 8'h14, 22'h3c2b1a, 16'h10ff);   // R3 reset wins
        run_trial(1'b1, 1'b0, 8'h80, 22'h123456, 16'h0002);   // R4 top source
        run_trial(1'b1, 1'b0, 8'hff, 22'h3fffff, 16'h0000);   // R2 all, R5 SP wrap
        run_trial(1'b1, 1'b0, 8'h01, 22'h000001, 16'h0001);   // R4 source 0
        run_trial(1'b1, 1'b0, 8'ha0, 22'h0abcde, 16'hffff);   // R2 lowest of two
        // Random mix.
        for (int t = 0; t < 400; t++) begin
            bit ge;
            bit r;
            logic [7:0] p;
            ge = ($urandom % 4) != 0;
            r  = ($urandom % 8) == 0;
            p  = 8'($urandom) & 8'($urandom);
            run_trial(ge, r, p, 22'($urandom), 16'($urandom));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule